// File: doc/BRIEF.md
# Fractional Baud Tick Generator

This block turns a fast reference clock into a single-cycle enable pulse whose rate is sixteen times a UART's bit rate. A UART sampler, a transmitter shift register or a parallel-port pacing timer uses the pulse as a clock enable. The divisor has a 14-bit whole part and a 3-bit fractional part counted in eighths of a reference cycle. With a 48 MHz reference, the bit rate is 3,000,000 / divisor. This spans roughly 183 baud up to 3 Mbaud.

A fraction cannot be counted directly, so it is built from whole cycles. In any eight consecutive output periods, exactly as many periods as the fraction's numerator last one extra reference cycle. A small phase accumulator chooses which periods those are, so the long ones are spread evenly rather than bunched together. The long-run average period is therefore exact.

A new divisor is written into a holding register. It becomes active only when the current output period ends, so a period already under way is never shortened.

Top module: `frac_baud_gen`

## Requirements
- R1: `tick` is high for single cycles. For a whole part n of 2 or more, the gap from one tick to the next is always either n or n+1 reference cycles.
- R2: For a divisor n + x/8 with n of 2 or more, any eight consecutive tick periods add up to exactly 8n + x reference cycles.
- R3: Periods are counted from the first period that uses a newly loaded divisor, starting at index k = 0. Period k is one cycle longer exactly when floor((k+1)x/8) is greater than floor(kx/8). So the first period after a load is never stretched.
- R4: A value of 0 in the whole-part field means 16384. With a zero fraction, ticks then come 16384 cycles apart.
- R5: A whole part of 1 with a zero fraction is allowed, and `tick` is then high on every cycle.
- R6: A written whole part of 1 with a nonzero fraction is replaced by exactly 2.0, and `clamp_err` reads 1 from the cycle after that write. Writing a permitted divisor clears `clamp_err` from the cycle after the write.
- R7: A divisor written in some cycle is first used for the period that begins at the first tick boundary strictly after the write. A write captured on the very clock edge where a period ends waits for the next boundary. The period under way when the write arrives finishes with its old length.
- R8: While `rst` is high, `tick` and `clamp_err` are 0 and the default divisor (26.0) is active. The first tick comes 26 cycles after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| div_wr | input | 1 | Write strobe for a new divisor |
| div_int | input | 14 | Whole part of the divisor; 0 means 16384 |
| div_frac | input | 3 | Fractional part of the divisor, in eighths |
| tick | output | 1 | Registered one-cycle enable at sixteen times the bit rate |
| clamp_err | output | 1 | The last write asked for a divisor between 1 and 2 and was clamped |

## Verification
Different kinds of internal fault show up at `tick` over different spans of time.

- A corrupted down-counter changes the very next tick gap, so it is visible within one period.
- A wrong phase accumulator keeps every single gap within n or n+1. It can be seen only in which periods are stretched and in the sum over eight periods, so it is exposed within eight periods of a load.
- A fault in the holding register shows up either as a shortened period right after a mid-period write or as a divisor applied one boundary too early or too late.

The bench therefore measures every gap for eight periods after each load, and it places writes both mid-period and on a boundary edge.

// File: rtl/fbg_pkg.sv
package fbg_pkg;
  // Classification of a divisor write.
  typedef enum logic [1:0] {
    WR_PLAIN = 2'd0,  // used as written
    WR_TOP   = 2'd1,  // whole field 0 -> maximum count
    WR_CLAMP = 2'd2   // forbidden 1 < d < 2 -> forced to 2.0
  } wr_kind_e;
endpackage

// File: rtl/fbg_shadow.sv
module fbg_shadow
  import fbg_pkg::*;
#(
  parameter int INT_W    = 14,
  parameter int FRAC_W   = 3,
  parameter int DEF_INT  = 26,
  parameter int DEF_FRAC = 0,
  localparam int CNT_W   = INT_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [INT_W-1:0]  wr_int,
  input  logic [FRAC_W-1:0] wr_frac,
  input  logic              take,
  output logic [CNT_W-1:0]  sel_int,
  output logic [FRAC_W-1:0] sel_frac,
  output logic              fresh,
  output logic [CNT_W-1:0]  act_int,
  output logic [FRAC_W-1:0] act_frac,
  output logic              err
);
  localparam int TOP_CNT = 2 ** INT_W;
  localparam logic [CNT_W-1:0] DEF_DEC =
    (DEF_INT == 0) ? CNT_W'(TOP_CNT) : CNT_W'(DEF_INT);

  wr_kind_e           kind;
  logic [CNT_W-1:0]   dec_int;
  logic [FRAC_W-1:0]  dec_frac;
  logic [CNT_W-1:0]   pend_int;
  logic [FRAC_W-1:0]  pend_frac;
  logic               pend_vld;
  logic               err_q;

  always_comb begin
    kind     = WR_PLAIN;
    dec_int  = {1'b0, wr_int};
    dec_frac = wr_frac;
    if (wr_int == '0) begin
      kind    = WR_TOP;
      dec_int = CNT_W'(TOP_CNT);
    end else if (wr_int == INT_W'(1) && wr_frac != '0) begin
      kind     = WR_CLAMP;
      dec_int  = CNT_W'(2);
      dec_frac = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_int  <= '0;
      pend_frac <= '0;
      pend_vld  <= 1'b0;
      act_int   <= DEF_DEC;
      act_frac  <= FRAC_W'(DEF_FRAC);
      err_q     <= 1'b0;
    end else begin
      if (take && pend_vld) begin
        act_int  <= pend_int;
        act_frac <= pend_frac;
        pend_vld <= 1'b0;
      end
      if (wr_en) begin
        pend_int  <= dec_int;
        pend_frac <= dec_frac;
        pend_vld  <= 1'b1;
        err_q     <= (kind == WR_CLAMP);
      end
    end
  end

  assign sel_int  = pend_vld ? pend_int  : act_int;
  assign sel_frac = pend_vld ? pend_frac : act_frac;
  assign fresh    = pend_vld;
  assign err      = err_q;

  // R6: a forbidden divisor raises the flag on the next cycle
  assert_clamp_flag_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_int == INT_W'(1) && wr_frac != '0) |=> err);

  // R7: the active divisor moves only on a period boundary
  assert_hold_until_boundary_R7: assert property (@(posedge clk) disable iff (rst)
    !take |=> ($stable(act_int) && $stable(act_frac)));
endmodule

// File: rtl/fbg_dither.sv
module fbg_dither #(
  parameter int FRAC_W   = 3,
  parameter int DEF_FRAC = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take,
  input  logic              fresh,
  input  logic [FRAC_W-1:0] sel_frac,
  output logic              stretch
);
  logic [FRAC_W-1:0] acc;
  logic [FRAC_W-1:0] base;
  logic [FRAC_W:0]   sum;

  assign base    = fresh ? '0 : acc;
  assign sum     = {1'b0, base} + {1'b0, sel_frac};
  assign stretch = sum[FRAC_W];

  // Reset behaves like a load whose first period has just been planned.
  always_ff @(posedge clk) begin
    if (rst)       acc <= FRAC_W'(DEF_FRAC);
    else if (take) acc <= sum[FRAC_W-1:0];
  end

  // R3: the first period planned after a load is never stretched
  assert_first_plain_R3: assert property (@(posedge clk) disable iff (rst)
    (take && fresh) |-> !stretch);

  // R2: a zero fraction never stretches a period
  assert_no_frac_no_stretch_R2: assert property (@(posedge clk) disable iff (rst)
    (sel_frac == '0) |-> !stretch);
endmodule

// File: rtl/fbg_counter.sv
module fbg_counter #(
  parameter int CNT_W = 15,
  parameter int RST_LEN = 26
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] sel_int,
  input  logic             stretch,
  output logic             take,
  output logic             tick
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cur_len;
  logic             tick_q;

  assign take = (cnt == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= CNT_W'(RST_LEN);
      cur_len <= CNT_W'(RST_LEN);
      tick_q  <= 1'b0;
    end else begin
      tick_q <= take;
      if (take) begin
        cnt     <= sel_int + CNT_W'(stretch);
        cur_len <= sel_int + CNT_W'(stretch);
      end else begin
        cnt <= cnt - CNT_W'(1);
      end
    end
  end

  assign tick = tick_q;

  // R1: the remaining count stays inside the period that was planned
  assert_count_in_period_R1: assert property (@(posedge clk) disable iff (rst)
    (cnt != '0) && (cnt <= cur_len));
endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen #(
  parameter int INT_W    = 14,
  parameter int FRAC_W   = 3,
  parameter int DEF_INT  = 26,
  parameter int DEF_FRAC = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              div_wr,
  input  logic [INT_W-1:0]  div_int,
  input  logic [FRAC_W-1:0] div_frac,
  output logic              tick,
  output logic              clamp_err
);
  localparam int CNT_W   = INT_W + 1;
  localparam int RST_LEN = (DEF_INT == 0) ? 2 ** INT_W : DEF_INT;

  logic [CNT_W-1:0]  sel_int;
  logic [FRAC_W-1:0] sel_frac;
  logic              fresh;
  logic              take;
  logic              stretch;
  logic [CNT_W-1:0]  act_int;
  logic [FRAC_W-1:0] act_frac;

  fbg_shadow #(
    .INT_W(INT_W), .FRAC_W(FRAC_W), .DEF_INT(DEF_INT), .DEF_FRAC(DEF_FRAC)
  ) u_shadow (
    .clk(clk), .rst(rst), .wr_en(div_wr), .wr_int(div_int), .wr_frac(div_frac),
    .take(take), .sel_int(sel_int), .sel_frac(sel_frac), .fresh(fresh),
    .act_int(act_int), .act_frac(act_frac), .err(clamp_err)
  );

  fbg_dither #(.FRAC_W(FRAC_W), .DEF_FRAC(DEF_FRAC)) u_dither (
    .clk(clk), .rst(rst), .take(take), .fresh(fresh),
    .sel_frac(sel_frac), .stretch(stretch)
  );

  fbg_counter #(.CNT_W(CNT_W), .RST_LEN(RST_LEN)) u_counter (
    .clk(clk), .rst(rst), .sel_int(sel_int), .stretch(stretch),
    .take(take), .tick(tick)
  );

  // R6: a whole part of 1 is only ever active with a zero fraction
  assert_top_rate_clean_R6: assert property (@(posedge clk) disable iff (rst)
    (act_int == CNT_W'(1)) |-> (act_frac == '0));

  // R5: the top rate keeps the tick asserted on back-to-back cycles
  assert_top_rate_ticks_R5: assert property (@(posedge clk) disable iff (rst)
    (take && !fresh && act_int == CNT_W'(1) && tick) |=> tick);
endmodule

// File: tb/sim_frac_baud_gen.sv
module sim_frac_baud_gen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        div_wr = 1'b0;
  logic [13:0] div_int = '0;
  logic [2:0]  div_frac = '0;
  logic        tick;
  logic        clamp_err;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  localparam int NV = 6;
  localparam int VINT [NV]  = '{3, 5, 7, 2, 10, 4};
  localparam int VFRAC [NV] = '{0, 4, 1, 7, 3, 5};

  always #4 clk = ~clk;

  frac_baud_gen u0 (
    .clk(clk), .rst(rst), .div_wr(div_wr), .div_int(div_int),
    .div_frac(div_frac), .tick(tick), .clamp_err(clamp_err)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000 && !done) begin
      checks++;
      errors++;
      $display("FAIL watchdog (R1..R8 run): actual %0d cycles expected fewer than 190000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic next_tick(output int c);
    c = 0;
    do begin
      @(negedge clk);
      c++;
    end while (tick !== 1'b1);
  endtask

  task automatic write_div(input int n, input int x);
    div_int  = 14'(n);
    div_frac = 3'(x);
    div_wr   = 1'b1;
    @(negedge clk);
    div_wr   = 1'b0;
  endtask

  initial begin
    int c;
    int sum;
    int exp;
    // R8: reset state
    repeat (4) @(negedge clk);
    chk(tick === 1'b0, "R8 tick in reset", int'(tick), 0);
    chk(clamp_err === 1'b0, "R8 flag in reset", int'(clamp_err), 0);
    rst = 1'b0;
    next_tick(c);
    chk(c == 26, "R8 first tick", c, 26);

    // R1 R2 R3: vector table, each write placed just after a tick
    for (int v = 0; v < NV; v++) begin
      write_div(VINT[v], VFRAC[v]);
      next_tick(c);
      sum = 0;
      for (int k = 0; k < 8; k++) begin
        next_tick(c);
        exp = VINT[v] + ((k + 1) * VFRAC[v]) / 8 - (k * VFRAC[v]) / 8;
        chk(c == exp, "R3 period pattern", c, exp);
        chk(c >= VINT[v] && c <= VINT[v] + 1, "R1 period bound", c, VINT[v]);
        sum += c;
      end
      chk(sum == 8 * VINT[v] + VFRAC[v], "R2 eight-period sum", sum, 8 * VINT[v] + VFRAC[v]);
    end

    // R7: a write mid-period leaves the running period intact
    write_div(40, 0);
    next_tick(c);
    c = 0;
    do begin
      @(negedge clk);
      c++;
      div_int  = 14'd3;
      div_frac = 3'd0;
      div_wr   = (c == 5);
    end while (tick !== 1'b1);
    div_wr = 1'b0;
    chk(c == 40, "R7 running period kept", c, 40);
    next_tick(c);
    chk(c == 3, "R7 new divisor applied", c, 3);

    // R7: a write captured on the boundary edge waits one more period
    c = 0;
    do begin
      @(negedge clk);
      c++;
      div_int  = 14'd6;
      div_frac = 3'd0;
      div_wr   = (c == 2);
    end while (tick !== 1'b1);
    div_wr = 1'b0;
    chk(c == 3, "R7 boundary period", c, 3);
    next_tick(c);
    chk(c == 3, "R7 deferred one period", c, 3);
    next_tick(c);
    chk(c == 6, "R7 deferred divisor", c, 6);

    // R6: clamp of a forbidden divisor
    write_div(1, 3);
    chk(clamp_err === 1'b1, "R6 flag raised", int'(clamp_err), 1);
    next_tick(c);
    next_tick(c);
    chk(c == 2, "R6 clamped period", c, 2);
    next_tick(c);
    chk(c == 2, "R6 clamped period again", c, 2);

    // R5: top rate, and R6: flag clears on a permitted write
    write_div(1, 0);
    chk(clamp_err === 1'b0, "R6 flag cleared", int'(clamp_err), 0);
    next_tick(c);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      chk(tick === 1'b1, "R5 tick every cycle", int'(tick), 1);
    end

    // R7: leaving the top rate
    write_div(12, 0);
    next_tick(c);
    chk(c == 1, "R7 last top-rate period", c, 1);
    next_tick(c);
    chk(c == 12, "R7 after top rate", c, 12);

    // R4: whole field 0 means 16384
    write_div(0, 0);
    next_tick(c);
    next_tick(c);
    chk(c == 16384, "R4 maximum divisor", c, 16384);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule